// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Output

This peripheral holds one 16-bit up-counter, seen by software as a low byte and a high byte. The counter runs in one of three modes. In capture mode it runs freely and latches its value into a holding register on an external trigger. In auto-reload mode it restarts from that register on overflow or on a trigger. In baud mode it produces periodic ticks for a serial receiver and transmitter. The count source is either a machine-cycle tick input (timer) or falling edges on a count pin (counter).

An overflow flag and an external-trigger flag feed one interrupt request, which is gated by an enable bit. Software reaches every register through a byte-wide write/read port. Both pins are asynchronous and pass through two-flop synchronizers before edge detection.

Top module: `caprel_timer`

## Requirements
- R1: After reset every register reads 0, and `irq_o`, `baud_rx_o` and `baud_tx_o` are low.
- R2: The register addresses are: 0 control, 1 count low, 2 count high, 3 holding low, 4 holding high, 5 interrupt enable (bit 0). The control bits are: bit0 run, bit1 counter select, bit2 capture select, bit3 receive-tick select, bit4 transmit-tick select, bit5 trigger enable, bit6 overflow flag, bit7 trigger flag. Writes land as written, and reads return register contents combinationally.
- R3: While run is 0 the count never advances, whatever the mode or count source.
- R4: In timer mode (bit1 = 0) the count rises by one for each clock with `tick_i` high. The high byte steps only when the low byte wraps from 0xFF to 0x00.
- R5: In counter mode (bit1 = 1) the count rises by exactly one per falling edge of `cnt_pin_i`, and `tick_i` is ignored. An edge acts three clock edges after the pin falls.
- R6: In capture mode (bit2 = 1, bits 3 and 4 clear), stepping past 0xFFFF sets the overflow flag and the count continues from 0x0000.
- R7: In capture mode, a falling edge on `trig_pin_i` with the trigger enable set copies the count (its value before any step in that cycle) into the holding register and sets the trigger flag. With the trigger enable clear, the edge does nothing. Each edge acts once.
- R8: In auto-reload mode (bits 2, 3 and 4 clear), stepping past 0xFFFF sets the overflow flag and loads the count from the holding register.
- R9: In auto-reload mode, an enabled trigger edge loads the count from the holding register and sets the trigger flag.
- R10: If bit3 or bit4 is set, baud mode applies whatever bit2 holds. Each overflow reloads the count and gives a one-clock pulse on both `baud_rx_o` and `baud_tx_o`. The overflow flag is not set.
- R11: In baud mode, an enabled trigger edge sets only the trigger flag. The count and the holding register are unchanged.
- R12: `irq_o` equals the enable bit AND (overflow flag OR trigger flag). The flags stay set until software writes them to 0.
- R13: A write to a count byte in the same cycle as a count step wins. The written byte takes the new value and the other byte is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Machine-cycle tick, the timer-mode count source |
| cnt_pin_i | input | 1 | Asynchronous count pin, counted on its falling edges |
| trig_pin_i | input | 1 | Asynchronous external trigger pin |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| baud_rx_o | output | 1 | Receive baud tick |
| baud_tx_o | output | 1 | Transmit baud tick |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can fall in one cycle: a software write to a count byte and a count step from the tick. The bench provokes this by raising `tick_i` in the same clock that carries a write to the low byte, and again for the high byte. It expects the written byte unchanged by the step and the other byte untouched. The swept counts, reload sequences and baud-pulse totals are computed arithmetically in the bench for each start value and tick count.

// File: rtl/caprel_timer.sv
`timescale 1ns/1ps
module caprel_timer #(
  parameter int BW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          cnt_pin_i,
  input  logic          trig_pin_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] rdata_o,
  output logic          baud_rx_o,
  output logic          baud_tx_o,
  output logic          irq_o
);
  localparam int CW = 2 * BW;
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_CLO = AW'(1), A_CHI = AW'(2),
                            A_RLO = AW'(3), A_RHI = AW'(4), A_IEN = AW'(5);

  logic [7:0]    ctrl;
  logic          ien;
  logic [BW-1:0] clo, chi, rlo, rhi;
  logic [1:0]    cnt_sync, trig_sync;
  logic          cnt_prev, trig_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_sync  <= 2'b11;
      trig_sync <= 2'b11;
      cnt_prev  <= 1'b1;
      trig_prev <= 1'b1;
    end else begin
      cnt_sync  <= {cnt_sync[0], cnt_pin_i};
      trig_sync <= {trig_sync[0], trig_pin_i};
      cnt_prev  <= cnt_sync[1];
      trig_prev <= trig_sync[1];
    end
  end

  wire cnt_fall  = cnt_prev & ~cnt_sync[1];
  wire trig_fall = trig_prev & ~trig_sync[1];

  wire run       = ctrl[0];
  wire ctsel     = ctrl[1];
  wire capsel    = ctrl[2];
  wire baud_mode = ctrl[3] | ctrl[4];
  wire exten     = ctrl[5];
  wire cap_mode  = ~baud_mode & capsel;
  wire rld_mode  = ~baud_mode & ~capsel;

  wire wr_ctrl = wr_en_i && addr_i == A_CTRL;
  wire wr_cnt  = wr_en_i && (addr_i == A_CLO || addr_i == A_CHI);
  wire trig_ev = trig_fall & exten;
  wire step    = run & (ctsel ? cnt_fall : tick_i) & ~wr_cnt;
  wire wrap    = step & (&{chi, clo});
  wire load    = ~wr_cnt & ((wrap & ~cap_mode) | (trig_ev & rld_mode));
  wire [CW-1:0] nxt = {chi, clo} + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clo <= '0;
      chi <= '0;
    end else if (wr_cnt) begin
      if (addr_i == A_CLO) clo <= wdata_i;
      else                 chi <= wdata_i;
    end else if (load) begin
      {chi, clo} <= {rhi, rlo};
    end else if (step) begin
      {chi, clo} <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rlo <= '0;
      rhi <= '0;
    end else begin
      if (wr_en_i && addr_i == A_RLO) rlo <= wdata_i;
      else if (trig_ev && cap_mode)   rlo <= clo;
      if (wr_en_i && addr_i == A_RHI) rhi <= wdata_i;
      else if (trig_ev && cap_mode)   rhi <= chi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      ien       <= 1'b0;
      baud_rx_o <= 1'b0;
      baud_tx_o <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= wdata_i[7:0];
      else begin
        if (wrap && !baud_mode) ctrl[6] <= 1'b1;
        if (trig_ev)            ctrl[7] <= 1'b1;
      end
      if (wr_en_i && addr_i == A_IEN) ien <= wdata_i[0];
      baud_rx_o <= wrap & baud_mode;
      baud_tx_o <= wrap & baud_mode;
    end
  end

  assign irq_o = ien & (ctrl[6] | ctrl[7]);

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = BW'(ctrl);
      A_CLO:   rdata_o = clo;
      A_CHI:   rdata_o = chi;
      A_RLO:   rdata_o = rlo;
      A_RHI:   rdata_o = rhi;
      A_IEN:   rdata_o = BW'(ien);
      default: rdata_o = '0;
    endcase
  end

  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt && !(trig_ev && rld_mode)) |=> $stable({chi, clo}));

  p_single_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_fall |=> !cnt_fall);

  p_cap_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode && wrap && !wr_ctrl) |=> (ctrl[6] && {chi, clo} == '0));

  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_mode && wrap) |=> {chi, clo} == $past({rhi, rlo}));

  p_baud_no_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_mode && !wr_ctrl && !ctrl[6]) |=> !ctrl[6]);

  p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7] && !wr_ctrl) |=> ctrl[7]);
endmodule

// File: tb/test_caprel_timer.sv
`timescale 1ns/1ps
module test_caprel_timer;
  logic clk = 0, rst_n = 0, tick = 0, cpin = 1, tpin = 1, we = 0;
  logic [2:0] addr = 0;
  logic [7:0] wd = 0, rd, v;
  logic brx, btx, irq;
  logic [15:0] c, exp16, rv;
  int vec = 0, bad = 0, nrx = 0, ntx = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  caprel_timer i_caprel_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_pin_i(cpin), .trig_pin_i(tpin),
    .wr_en_i(we), .addr_i(addr), .wdata_i(wd), .rdata_o(rd),
    .baud_rx_o(brx), .baud_tx_o(btx), .irq_o(irq));

  always @(negedge clk) begin
    if (brx) nrx++;
    if (btx) ntx++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wd = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rdv(input logic [2:0] a);
    @(negedge clk); addr = a; #1 v = rd;
  endtask

  task automatic rdcnt();
    rdv(2); c[15:8] = v;
    rdv(1); c[7:0] = v;
  endtask

  task automatic setcnt(input logic [15:0] x);
    wr(1, x[7:0]); wr(2, x[15:8]);
  endtask

  task automatic setrld(input logic [15:0] x);
    wr(3, x[7:0]); wr(4, x[15:8]);
  endtask

  task automatic ticks(input int k);
    repeat (k) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic cedge();
    @(negedge clk); cpin = 0;
    repeat (4) @(negedge clk);
    cpin = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic tedge();
    @(negedge clk); tpin = 0;
    repeat (4) @(negedge clk);
    tpin = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #750000;
    if (!done) begin
      bad++; vec++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] starts [3];
    starts[0] = 16'h00F0; starts[1] = 16'h12FE; starts[2] = 16'hFFFA;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 6; a++) begin
      rdv(a[2:0]); chk($sformatf("R1 reg %0d", a), v, 0);
    end
    chk("R1 irq", irq, 0); chk("R1 baud rx", brx, 0); chk("R1 baud tx", btx, 0);

    // R2 R4 R6: timer-mode capture sweep with carry and overflow
    for (int s = 0; s < 3; s++)
      for (int k = 0; k <= 10; k++) begin
        wr(0, 8'h05); setcnt(starts[s]); ticks(k);
        exp16 = starts[s] + 16'(k);
        rdcnt(); chk($sformatf("R4 count s=%0h k=%0d", starts[s], k), c, exp16);
        rdv(0); chk("R6 ovf flag", v, 8'h05 | ((32'(starts[s]) + k > 32'hFFFF) ? 8'h40 : 8'h00));
      end

    // R3: stopped in several modes
    wr(0, 8'h04); setcnt(16'h1111); ticks(6);
    rdcnt(); chk("R3 stopped capture timer", c, 16'h1111);
    wr(0, 8'h06); cedge(); cedge();
    rdcnt(); chk("R3 stopped counter", c, 16'h1111);
    wr(0, 8'h00); setcnt(16'hFFFF); ticks(3);
    rdcnt(); chk("R3 stopped reload", c, 16'hFFFF);

    // R5: counter mode, tick held high and ignored
    for (int m = 0; m <= 5; m++) begin
      wr(0, 8'h07); setcnt(16'h00FE); tick = 1;
      repeat (m) cedge();
      repeat (3) @(negedge clk);
      tick = 0;
      rdcnt(); chk($sformatf("R5 edges=%0d", m), c, 16'h00FE + 16'(m));
    end

    // R7: capture on trigger, and ignored without enable
    wr(0, 8'h25); setcnt(16'h5A3C); tedge();
    rdv(4); rv[15:8] = v; rdv(3); rv[7:0] = v;
    chk("R7 captured", rv, 16'h5A3C);
    rdv(0); chk("R7 trig flag", v, 8'hA5);
    wr(0, 8'h05); setcnt(16'h0101); tedge();
    rdv(4); rv[15:8] = v; rdv(3); rv[7:0] = v;
    chk("R7 disabled no capture", rv, 16'h5A3C);
    rdv(0); chk("R7 disabled no flag", v, 8'h05);

    // R8: auto-reload sweep
    for (int k = 0; k <= 24; k++) begin
      logic o;
      wr(0, 8'h01); setrld(16'hFFF0); setcnt(16'hFFFD); ticks(k);
      exp16 = 16'hFFFD; o = 0;
      for (int i = 0; i < k; i++)
        if (exp16 == 16'hFFFF) begin exp16 = 16'hFFF0; o = 1; end
        else exp16++;
      rdcnt(); chk($sformatf("R8 reload count k=%0d", k), c, exp16);
      rdv(0); chk("R8 ovf flag", v, o ? 8'h41 : 8'h01);
    end

    // R9: trigger-forced reload
    wr(0, 8'h21); setrld(16'hABCD); setcnt(16'h1234); tedge();
    rdcnt(); chk("R9 trig reload", c, 16'hABCD);
    rdv(0); chk("R9 trig flag", v, 8'hA1);

    // R10: baud mode, priority over capture select
    wr(0, 8'h0D); setrld(16'hFFFC); setcnt(16'hFFFC);
    repeat (2) @(negedge clk);
    nrx = 0; ntx = 0; ticks(20); repeat (2) @(negedge clk);
    chk("R10 rx pulses", nrx, 5); chk("R10 tx pulses", ntx, 5);
    rdcnt(); chk("R10 reloaded", c, 16'hFFFC);
    rdv(0); chk("R10 no ovf flag", v, 8'h0D);
    wr(0, 8'h11); setcnt(16'hFFFC);
    nrx = 0; ntx = 0; ticks(8); repeat (2) @(negedge clk);
    chk("R10 tx-select rx pulses", nrx, 2); chk("R10 tx-select tx pulses", ntx, 2);

    // R11: baud-mode trigger sets only the flag
    wr(0, 8'h29); setcnt(16'h3333); tedge();
    rdcnt(); chk("R11 count kept", c, 16'h3333);
    rdv(4); rv[15:8] = v; rdv(3); rv[7:0] = v;
    chk("R11 holding kept", rv, 16'hFFFC);
    rdv(0); chk("R11 flag", v, 8'hA9);

    // R12: interrupt gating and sticky flags
    @(negedge clk); chk("R12 irq gated off", irq, 0);
    wr(5, 8'h01); chk("R12 irq on trig flag", irq, 1);
    wr(0, 8'h29); chk("R12 irq cleared", irq, 0);
    wr(0, 8'h45); repeat (10) @(negedge clk);
    chk("R12 irq on ovf flag sticky", irq, 1);
    wr(5, 8'h00); chk("R12 irq disabled", irq, 0);

    // R13: write beats step in the same cycle
    wr(0, 8'h05); setcnt(16'h10FF);
    @(negedge clk); we = 1; addr = 1; wd = 8'h77; tick = 1;
    @(negedge clk); we = 0; tick = 0;
    rdcnt(); chk("R13 low write wins", c, 16'h1077);
    @(negedge clk); we = 1; addr = 2; wd = 8'h22; tick = 1;
    @(negedge clk); we = 0; tick = 0;
    rdcnt(); chk("R13 high write wins", c, 16'h2277);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule